// File: doc/BRIEF.md
# Stepped 8-bit ALU with Status Flags

This block is an 8-bit arithmetic logic unit placed behind a small step sequencer. A single step strobe walks the block through five fixed stages. The first stage captures operand A. The second captures operand B. The third latches a 3-bit operation code. The fourth evaluates the operation and registers the result together with zero, carry, overflow and negative flags. The fifth presents that result with a ready indication. The next step returns the sequencer to the operand A stage.

Each stage samples only the input that belongs to it, so the driving logic can reuse one set of wires and change them freely between steps. The result and flags stay registered and unchanged until the next compute stage. Ready is high only while the sequencer sits in the output stage.

Top module: `alu8_stepper`

## Requirements
- R1: Opcode 3'b000 adds A and B through a ripple carry chain with carry-in 0, and C is set when the sum needs a ninth bit (0x0F+0x0A gives 0x19 with C=0; 0xC8+0x64 gives 0x2C with C=1).
- R2: Opcode 3'b001 computes A minus B modulo 256, and C is set exactly when unsigned A is less than B, which is a borrow.
- R3: The Z output is high exactly when the 8-bit result is 0x00, for every opcode.
- R4: For add and subtract, V is high exactly when the true signed result lies outside -128..127 (0x7F+0x01 gives 0x80 with V=1).
- R5: The N output always equals bit 7 of the result.
- R6: Opcodes 3'b010, 3'b011 and 3'b100 give A AND B, A OR B and A XOR B. Opcode 3'b101 gives the bitwise complement of A and is unaffected by B. For all four, C and V are 0.
- R7: Opcode 3'b110 shifts A left and opcode 3'b111 shifts A right logically, both by the unsigned value of B, filling with zeros. A shift amount of 8 or more gives 0x00. C and V are 0.
- R8: Each clock cycle with step_i high advances the stage in the order load A, load B, select op, compute, output, then back to load A. Each operand and the opcode are taken only in their own stage. Inputs in any other stage do not change the result.
- R9: ready_o rises on the clock edge that completes the compute stage. It stays high, with the result and flags unchanged, through any number of idle cycles, and falls on the next step.
- R10: Reset puts the sequencer in the load A stage and clears the result, all flags and ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| step_i | input | 1 | Advance the sequencer by one stage |
| a_i | input | 8 | Operand A, taken in the load A stage |
| b_i | input | 8 | Operand B or shift amount, taken in the load B stage |
| op_i | input | 3 | Operation code, taken in the select stage |
| result_o | output | 8 | Registered result |
| zero_o | output | 1 | Result is zero |
| carry_o | output | 1 | Carry out on add, borrow on subtract |
| ovf_o | output | 1 | Signed overflow on add or subtract |
| neg_o | output | 1 | Bit 7 of the result |
| ready_o | output | 1 | Result and flags valid, output stage |

## Verification
The step that leaves the output stage falls in the same cycle as the drop of ready and as fresh operand values arriving for the next operation. The scoreboard therefore drives a new, conflicting value on a_i, b_i and op_i during every step that is not a capture step, including the output step. It then judges each result only against the values shown in the matching capture stage. In the same way, the flag update and the rise of ready share the compute-stage edge. The monitor compares result and all four flags in the first cycle it sees ready high, and then checks that they hold through idle gaps of varying length.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [2:0] {
    ST_LOAD_A  = 3'd0,
    ST_LOAD_B  = 3'd1,
    ST_SEL_OP  = 3'd2,
    ST_COMPUTE = 3'd3,
    ST_OUTPUT  = 3'd4
  } stage_e;

  typedef enum logic [2:0] {
    OP_ADD = 3'b000,
    OP_SUB = 3'b001,
    OP_AND = 3'b010,
    OP_OR  = 3'b011,
    OP_XOR = 3'b100,
    OP_NOT = 3'b101,
    OP_SHL = 3'b110,
    OP_SHR = 3'b111
  } op_e;

  typedef struct packed {
    logic zero;
    logic carry;
    logic ovf;
    logic neg;
  } flags_t;

endpackage

// File: rtl/alu8_ripple.sv
module alu8_ripple #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         cmsb
);
  logic [W:0] c;

  assign c[0] = cin;

  genvar i;
  for (i = 0; i < W; i++) begin : g_bit
    assign sum[i] = a[i] ^ b[i] ^ c[i];
    assign c[i+1] = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
  end

  assign cout = c[W];
  // carry into the sign bit, for overflow detection
  assign cmsb = c[W-1];
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  op_e          op,
  output logic [W-1:0] res,
  output flags_t       fl
);
  localparam int SW = $clog2(W);
  localparam logic [W-1:0] W_LIM = W[W-1:0];

  logic         is_sub;
  logic [W-1:0] b_eff;
  logic [W-1:0] sum;
  logic         cout;
  logic         cmsb;
  logic [SW-1:0] shamt;
  logic         shift_all;

  assign is_sub = (op == OP_SUB);
  assign b_eff  = is_sub ? ~b : b;

  alu8_ripple #(.W(W)) u_add (
    .a    (a),
    .b    (b_eff),
    .cin  (is_sub),
    .sum  (sum),
    .cout (cout),
    .cmsb (cmsb)
  );

  assign shamt     = b[SW-1:0];
  assign shift_all = (b >= W_LIM);

  always_comb begin
    res      = '0;
    fl.carry = 1'b0;
    fl.ovf   = 1'b0;
    unique case (op)
      OP_ADD, OP_SUB: begin
        res      = sum;
        fl.carry = is_sub ? ~cout : cout;
        fl.ovf   = cout ^ cmsb;
      end
      OP_AND: res = a & b;
      OP_OR:  res = a | b;
      OP_XOR: res = a ^ b;
      OP_NOT: res = ~a;
      OP_SHL: res = shift_all ? '0 : (a << shamt);
      OP_SHR: res = shift_all ? '0 : (a >> shamt);
      default: res = '0;
    endcase
    fl.zero = (res == '0);
    fl.neg  = res[W-1];
  end
endmodule

// File: rtl/alu8_seq.sv
module alu8_seq
  import alu8_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_n,
  input  logic   step_i,
  output stage_e stage_q,
  output logic   ld_a,
  output logic   ld_b,
  output logic   ld_op,
  output logic   do_compute,
  output logic   leave_out
);
  stage_e stage_d;

  always_comb begin
    stage_d = stage_q;
    if (step_i) begin
      unique case (stage_q)
        ST_LOAD_A:  stage_d = ST_LOAD_B;
        ST_LOAD_B:  stage_d = ST_SEL_OP;
        ST_SEL_OP:  stage_d = ST_COMPUTE;
        ST_COMPUTE: stage_d = ST_OUTPUT;
        ST_OUTPUT:  stage_d = ST_LOAD_A;
        default:    stage_d = ST_LOAD_A;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) stage_q <= ST_LOAD_A;
    else        stage_q <= stage_d;
  end

  assign ld_a       = step_i && (stage_q == ST_LOAD_A);
  assign ld_b       = step_i && (stage_q == ST_LOAD_B);
  assign ld_op      = step_i && (stage_q == ST_SEL_OP);
  assign do_compute = step_i && (stage_q == ST_COMPUTE);
  assign leave_out  = step_i && (stage_q == ST_OUTPUT);
endmodule

// File: rtl/alu8_stepper.sv
module alu8_stepper
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [2:0]   op_i,
  output logic [W-1:0] result_o,
  output logic         zero_o,
  output logic         carry_o,
  output logic         ovf_o,
  output logic         neg_o,
  output logic         ready_o
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  stage_e stage_q;
  logic   ld_a, ld_b, ld_op, do_compute, leave_out;

  alu8_seq u_seq (
    .clk_i      (clk_i),
    .rst_n      (rst_n),
    .step_i     (step_i),
    .stage_q    (stage_q),
    .ld_a       (ld_a),
    .ld_b       (ld_b),
    .ld_op      (ld_op),
    .do_compute (do_compute),
    .leave_out  (leave_out)
  );

  logic [W-1:0] a_q, b_q, res_q, res_d;
  op_e          op_q;
  flags_t       fl_q, fl_d;
  logic         ready_q, ready_d;

  alu8_core #(.W(W)) u_core (
    .a   (a_q),
    .b   (b_q),
    .op  (op_q),
    .res (res_d),
    .fl  (fl_d)
  );

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      a_q  <= '0;
      b_q  <= '0;
      op_q <= OP_ADD;
    end else begin
      if (ld_a)  a_q  <= a_i;
      if (ld_b)  b_q  <= b_i;
      if (ld_op) op_q <= op_e'(op_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      fl_q  <= '0;
    end else if (do_compute) begin
      res_q <= res_d;
      fl_q  <= fl_d;
    end
  end

  always_comb begin
    ready_d = ready_q;
    if (do_compute)     ready_d = 1'b1;
    else if (leave_out) ready_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= ready_d;
  end

  assign result_o = res_q;
  assign zero_o   = fl_q.zero;
  assign carry_o  = fl_q.carry;
  assign ovf_o    = fl_q.ovf;
  assign neg_o    = fl_q.neg;
  assign ready_o  = ready_q;
endmodule

// File: rtl/alu8_stepper_chk.sv
module alu8_stepper_chk
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_n,
  input logic         step_i,
  input logic [W-1:0] result_o,
  input logic         zero_o,
  input logic         carry_o,
  input logic         ovf_o,
  input logic         neg_o,
  input logic         ready_o,
  input stage_e       stage_q,
  input op_e          op_q
);
  AST_ZERO_MATCH: assert property (@(posedge clk_i) disable iff (!rst_n)
    ready_o |-> (zero_o == (result_o == '0))); // R3

  AST_NEG_MSB: assert property (@(posedge clk_i) disable iff (!rst_n)
    ready_o |-> (neg_o == result_o[W-1])); // R5

  AST_LOGIC_NO_CV: assert property (@(posedge clk_i) disable iff (!rst_n)
    (ready_o && op_q != OP_ADD && op_q != OP_SUB) |-> (!carry_o && !ovf_o)); // R6

  AST_READY_IN_OUTPUT: assert property (@(posedge clk_i) disable iff (!rst_n)
    ready_o |-> (stage_q == ST_OUTPUT)); // R9

  AST_READY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n)
    (ready_o && !step_i) |=> (ready_o && $stable(result_o))); // R9

  AST_READY_DROP: assert property (@(posedge clk_i) disable iff (!rst_n)
    (ready_o && step_i) |=> (!ready_o && stage_q == ST_LOAD_A)); // R8
endmodule

bind alu8_stepper alu8_stepper_chk #(.W(W)) chk_i (
  .clk_i    (clk_i),
  .rst_n    (rst_n),
  .step_i   (step_i),
  .result_o (result_o),
  .zero_o   (zero_o),
  .carry_o  (carry_o),
  .ovf_o    (ovf_o),
  .neg_o    (neg_o),
  .ready_o  (ready_o),
  .stage_q  (stage_q),
  .op_q     (op_q)
);

// File: tb/alu8_stepper_tb_top.sv
`timescale 1ns/1ps
module alu8_stepper_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       step_i = 1'b0;
  logic [7:0] a_i = '0;
  logic [7:0] b_i = '0;
  logic [2:0] op_i = '0;
  logic [7:0] result_o;
  logic       zero_o, carry_o, ovf_o, neg_o, ready_o;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] res;
    logic z, c, v, n;
    logic [2:0] op;
  } exp_t;

  exp_t sb_q[$];

  always #2.5 clk_i = ~clk_i;

  alu8_stepper dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step_i),
    .a_i(a_i), .b_i(b_i), .op_i(op_i),
    .result_o(result_o), .zero_o(zero_o), .carry_o(carry_o),
    .ovf_o(ovf_o), .neg_o(neg_o), .ready_o(ready_o)
  );

  function automatic string req_of(input logic [2:0] op);
    case (op)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b110, 3'b111: return "R7";
      default: return "R6";
    endcase
  endfunction

  function automatic exp_t model(input logic [7:0] a, input logic [7:0] b, input logic [2:0] op);
    exp_t e;
    int ua, ub, sa, sb, t, st;
    ua = a; ub = b; sa = $signed(a); sb = $signed(b);
    e.c = 0; e.v = 0; e.op = op;
    case (op)
      3'b000: begin t = ua + ub; e.res = t[7:0]; e.c = (t > 255);
                    st = sa + sb; e.v = (st > 127) || (st < -128); end
      3'b001: begin t = ua - ub; e.res = t[7:0]; e.c = (ua < ub);
                    st = sa - sb; e.v = (st > 127) || (st < -128); end
      3'b010: e.res = a & b;
      3'b011: e.res = a | b;
      3'b100: e.res = a ^ b;
      3'b101: e.res = ~a;
      3'b110: e.res = (ub >= 8) ? 8'h00 : 8'(a << ub);
      default: e.res = (ub >= 8) ? 8'h00 : 8'(a >> ub);
    endcase
    e.z = (e.res == 8'h00);
    e.n = e.res[7];
    return e;
  endfunction

  task automatic check1(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one step pulse; starts and ends at a falling edge
  task automatic do_step();
    step_i = 1'b1;
    @(negedge clk_i);
    step_i = 1'b0;
  endtask

  // driver: full five-stage operation with conflicting values outside capture stages
  task automatic run_op(input logic [7:0] a, input logic [7:0] b, input logic [2:0] op, input int gap);
    sb_q.push_back(model(a, b, op));
    a_i = a;  b_i = ~b; op_i = ~op;
    do_step();
    check1("R9", "ready after load A", {7'b0, ready_o}, 8'h00);
    a_i = ~a; b_i = b;  op_i = ~op;
    do_step();
    check1("R9", "ready after load B", {7'b0, ready_o}, 8'h00);
    a_i = a ^ 8'h5A; b_i = b ^ 8'hA5; op_i = op;
    do_step();
    check1("R9", "ready after select", {7'b0, ready_o}, 8'h00);
    a_i = ~a; b_i = ~b; op_i = ~op;
    do_step();
    check1("R9", "ready after compute", {7'b0, ready_o}, 8'h01);
    for (int k = 0; k < gap; k++) @(negedge clk_i);
    if (gap > 0) begin
      check1("R9", "ready held in idle", {7'b0, ready_o}, 8'h01);
      check1("R9", "result held in idle", result_o, model(a, b, op).res);
    end
    a_i = ~a; b_i = ~b; op_i = ~op;
    do_step();
    check1("R8", "ready after output step", {7'b0, ready_o}, 8'h00);
  endtask

  // monitor: compare on first cycle with ready high
  initial begin
    bit prev = 0;
    forever begin
      @(negedge clk_i);
      if (ready_o && !prev) begin
        if (sb_q.size() == 0) begin
          vectors++; miscompares++;
          $display("FAIL R9: actual ready 1 expected no pending result");
        end else begin
          exp_t e;
          string r;
          e = sb_q.pop_front();
          r = req_of(e.op);
          check1(r, "result", result_o, e.res);
          check1("R3", "zero flag", {7'b0, zero_o}, {7'b0, e.z});
          check1((e.op == 3'b001) ? "R2" : r, "carry flag", {7'b0, carry_o}, {7'b0, e.c});
          check1((e.op <= 3'b001) ? "R4" : r, "overflow flag", {7'b0, ovf_o}, {7'b0, e.v});
          check1("R5", "negative flag", {7'b0, neg_o}, {7'b0, e.n});
        end
      end
      prev = ready_o;
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    vectors++; miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R10: reset state
    check1("R10", "reset result", result_o, 8'h00);
    check1("R10", "reset flags", {4'b0, zero_o, carry_o, ovf_o, neg_o}, 8'h00);
    check1("R10", "reset ready", {7'b0, ready_o}, 8'h00);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);

    run_op(8'h0F, 8'h0A, 3'b000, 0);   // R1 0x19
    run_op(8'hC8, 8'h64, 3'b000, 2);   // R1 carry
    run_op(8'h7F, 8'h01, 3'b000, 0);   // R4 overflow
    run_op(8'h05, 8'h05, 3'b001, 1);   // R2 R3 zero
    run_op(8'h05, 8'h0A, 3'b001, 0);   // R2 borrow, R5
    run_op(8'h80, 8'h01, 3'b001, 3);   // R4 sub overflow
    run_op(8'hF0, 8'h3C, 3'b010, 0);   // R6
    run_op(8'hF0, 8'h0F, 3'b011, 0);   // R6
    run_op(8'hFF, 8'hFF, 3'b100, 0);   // R6 R3
    run_op(8'h0F, 8'hFF, 3'b101, 0);   // R6 B ignored
    run_op(8'h0F, 8'h00, 3'b101, 0);   // R6 B ignored
    run_op(8'h81, 8'h03, 3'b110, 0);   // R7
    run_op(8'h81, 8'h08, 3'b111, 0);   // R7 amount 8
    run_op(8'h80, 8'h07, 3'b111, 0);   // R7 logical fill
    run_op(8'hFF, 8'hC8, 3'b110, 0);   // R7 large amount
    run_op(8'hFF, 8'h00, 3'b111, 1);   // R7 amount 0
    for (int i = 0; i < 40; i++)
      run_op(8'($urandom), 8'($urandom_range(0, 12)) ^ ((i % 3 == 0) ? 8'($urandom) : 8'h00),
             3'(i % 8), i % 3);

    // R10: reset mid-sequence returns to load A with outputs cleared
    a_i = 8'h11; do_step();
    b_i = 8'h22; do_step();
    rst_ni = 1'b0;
    @(negedge clk_i);
    check1("R10", "mid reset result", result_o, 8'h00);
    check1("R10", "mid reset ready", {7'b0, ready_o}, 8'h00);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    run_op(8'h33, 8'h44, 3'b000, 0);   // R8 starts at load A again

    repeat (3) @(negedge clk_i);
    vectors++;
    if (sb_q.size() != 0) begin
      miscompares++;
      $display("FAIL R9: actual %0d results missing expected 0", sb_q.size());
    end
    finish_run();
  end
endmodule